// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block sits between a simple synchronous bus and an on-chip word array that stands in for a parallel NOR flash. Every bus write is taken as one cycle of a command sequence: a first cycle names an operation, and the following cycles supply addresses, data, a word count or a confirm code. The interpreter updates the array, keeps an 8-bit status register with a ready flag and two error flags, and selects the source of each read. A read returns array words, the status byte, identifier bytes or query bytes, depending on the current read mode.

The bus is `LANES` devices of `DEV_W` bits each, side by side. Status, identifier and query bytes appear in every device lane. Command and confirm codes are always taken from `wdata[7:0]`. A block erase is carried out one word per clock, and ready reads as zero until the erase finishes. A separate input marks the array as read-only. When it is set, program and erase attempts report errors and leave the contents unchanged. Lock and unlock sequences are decoded and acknowledged, but they protect nothing.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset the block is in array-read mode and the status byte is 0x80. Array contents are not changed by reset.
- R2: A read strobe at clock edge t gives `rvalid` high and `rdata` valid after edge t only, for one cycle per strobe. In array mode, `rdata` is the stored word at `addr`.
- R3: A first cycle of 0x10 or 0x40 selects a single-word program. The next write stores its data at its address. Status bit 7 is set, and later reads return status until another mode is selected.
- R4: 0x20 followed by 0xD0 fills every word of the aligned `SECTOR_WORDS`-word sector holding the address with all ones, one word per clock. Status bit 7 is clear while the erase runs, any bus write in that time is ignored, and bit 7 is set when the erase ends.
- R5: 0x20 followed by 0xFF, or by any code other than 0xD0, cancels the erase, returns to array mode and changes no word.
- R6: 0xE8 sets status bit 7 and selects status reads. The next write gives a count N from its low `DEV_W` bits, and N+1 data writes follow, each stored at its own address. A confirm of 0xD0 then sets bit 7 and keeps status reads.
- R7: A confirm other than 0xD0 after a buffered write sets status bit 4 and returns to array mode. The data words already written stay stored.
- R8: 0x60 followed by 0x01 (lock) or 0xD0 (unlock) sets status bit 7, selects status reads and leaves the array unchanged. 0x60 followed by 0xFF or by any other code returns to array mode.
- R9: 0x50 clears the whole status byte to 0x00 and selects array mode. Status bits 6 and 3..0 are always zero.
- R10: After 0x90, a read at word offset 0 returns the manufacturer byte `MFR_ID` and offset 1 returns the part byte `PART_ID`. Any other offset returns 0. The byte appears in each device lane.
- R11: After 0x98, query offsets 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Offsets 0x13 and 0x2C return 0x01, and every other offset returns 0. The byte appears in each device lane.
- R12: While `array_ro` is high, a program or buffered data write sets status bit 4 and an erase confirm sets bit 5 plus bit 7. In each case no word changes.
- R13: In status mode each `DEV_W`-bit lane of `rdata` holds the status byte, zero-extended.
- R14: An unrecognised first-cycle code resets the sequence and selects array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| array_ro | input | 1 | Array is read-only: program and erase report errors |
| wr_en | input | 1 | Bus write strobe (one command cycle) |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address for both reads and writes |
| wdata | input | LANES*DEV_W | Write data; command codes in bits 7..0 |
| rdata | output | LANES*DEV_W | Read data, valid while rvalid is high |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The embedded assertions check these on every cycle:
- the status byte and read mode right after reset;
- ready is low for the whole erase window;
- the reserved status bits stay zero;
- no array write happens while the array is read-only;
- the read-valid timing;
- the result of a bad buffered-write confirm.

Sector alignment, the masked word count, identifier and query contents, lane replication, and the fact that ignored or aborted sequences leave memory untouched depend on array contents. Only the bench's read-back scenarios can show those.

// File: rtl/flash_cmd_pkg.sv
// Shared definitions for the flash command interpreter: command codes,
// status bit positions, sequence states and read modes.
package flash_cmd_pkg;

    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_CLR_STAT = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BUFFER   = 8'hE8;
    localparam logic [7:0] OP_ARRAY    = 8'hFF;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCK_SET = 8'h01;

    localparam int SB_READY   = 7;
    localparam int SB_ERS_ERR = 5;
    localparam int SB_PGM_ERR = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PROG,
        SQ_ERASE_ARM,
        SQ_ERASE_RUN,
        SQ_LOCK_ARM,
        SQ_BUF_COUNT,
        SQ_BUF_DATA,
        SQ_BUF_CONFIRM
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_IDENT,
        RM_QUERY
    } read_mode_t;

endpackage

// File: rtl/flash_word_array.sv
// Word-wide storage standing in for the flash array.
// Assumes one write port and one synchronous read port; contents have no reset.
module flash_word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word when the write port is enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read of one word.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/flash_seq_fsm.sv
// Command sequence decoder. Tracks the write cycle within a sequence, owns
// the status byte and the read mode, and drives the array write port.
// Assumes DEV_W >= 8 and SECTOR_WORDS a power of two below the array depth.
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int DEV_W        = 8,
    parameter int LANES        = 2,
    parameter int SECTOR_WORDS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   array_ro,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DEV_W*LANES-1:0] wdata,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_waddr,
    output logic [DEV_W*LANES-1:0] mem_wdata,
    output logic [7:0]             status,
    output read_mode_t             rmode
);
    localparam int BUS_W    = DEV_W * LANES;
    localparam int SEC_BITS = $clog2(SECTOR_WORDS);
    localparam int SEC_IDXW = ADDR_W - SEC_BITS;
    localparam logic [SEC_BITS-1:0] SEC_LAST = SEC_BITS'(SECTOR_WORDS - 1);

    seq_state_t          state;
    logic [DEV_W-1:0]    remain;
    logic [SEC_IDXW-1:0] ers_sector;
    logic [SEC_BITS-1:0] ers_idx;
    logic [7:0]          cmd;

    assign cmd = wdata[7:0];

    // Array write port: the erase engine owns it while running, else data cycles.
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = addr;
        mem_wdata = wdata;
        if (state == SQ_ERASE_RUN) begin
            mem_we    = 1'b1;
            mem_waddr = {ers_sector, ers_idx};
            mem_wdata = {BUS_W{1'b1}};
        end else if (wr_en && !array_ro &&
                     (state == SQ_PROG || state == SQ_BUF_DATA)) begin
            mem_we = 1'b1;
        end
    end

    // Sequence state, status byte and read mode update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            rmode      <= RM_ARRAY;
            status     <= 8'h80;
            remain     <= '0;
            ers_sector <= '0;
            ers_idx    <= '0;
        end else if (state == SQ_ERASE_RUN) begin
            ers_idx <= ers_idx + 1'b1;
            if (ers_idx == SEC_LAST) begin
                status[SB_READY] <= 1'b1;
                state            <= SQ_IDLE;
            end
        end else if (wr_en) begin
            case (state)
                SQ_IDLE: begin
                    case (cmd)
                        OP_PROG_A, OP_PROG_B: begin
                            state <= SQ_PROG;
                            rmode <= RM_STATUS;
                        end
                        OP_ERASE: begin
                            state <= SQ_ERASE_ARM;
                            rmode <= RM_STATUS;
                        end
                        OP_CLR_STAT: begin
                            status <= 8'h00;
                            rmode  <= RM_ARRAY;
                        end
                        OP_LOCK: begin
                            state <= SQ_LOCK_ARM;
                            rmode <= RM_STATUS;
                        end
                        OP_STATUS: rmode <= RM_STATUS;
                        OP_IDENT:  rmode <= RM_IDENT;
                        OP_QUERY:  rmode <= RM_QUERY;
                        OP_BUFFER: begin
                            status[SB_READY] <= 1'b1;
                            state            <= SQ_BUF_COUNT;
                            rmode            <= RM_STATUS;
                        end
                        default: begin
                            state <= SQ_IDLE;
                            rmode <= RM_ARRAY;
                        end
                    endcase
                end
                SQ_PROG: begin
                    if (array_ro) status[SB_PGM_ERR] <= 1'b1;
                    status[SB_READY] <= 1'b1;
                    state            <= SQ_IDLE;
                    rmode            <= RM_STATUS;
                end
                SQ_ERASE_ARM: begin
                    if (cmd == OP_CONFIRM) begin
                        rmode <= RM_STATUS;
                        if (array_ro) begin
                            status[SB_ERS_ERR] <= 1'b1;
                            status[SB_READY]   <= 1'b1;
                            state              <= SQ_IDLE;
                        end else begin
                            ers_sector       <= addr[ADDR_W-1:SEC_BITS];
                            ers_idx          <= '0;
                            status[SB_READY] <= 1'b0;
                            state            <= SQ_ERASE_RUN;
                        end
                    end else begin
                        state <= SQ_IDLE;
                        rmode <= RM_ARRAY;
                    end
                end
                SQ_LOCK_ARM: begin
                    if (cmd == OP_LOCK_SET || cmd == OP_CONFIRM) begin
                        status[SB_READY] <= 1'b1;
                        rmode            <= RM_STATUS;
                    end else begin
                        rmode <= RM_ARRAY;
                    end
                    state <= SQ_IDLE;
                end
                SQ_BUF_COUNT: begin
                    remain <= wdata[DEV_W-1:0];
                    state  <= SQ_BUF_DATA;
                end
                SQ_BUF_DATA: begin
                    if (array_ro) status[SB_PGM_ERR] <= 1'b1;
                    if (remain == '0) begin
                        state <= SQ_BUF_CONFIRM;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                SQ_BUF_CONFIRM: begin
                    if (cmd == OP_CONFIRM) begin
                        status[SB_READY] <= 1'b1;
                        rmode            <= RM_STATUS;
                    end else begin
                        status[SB_PGM_ERR] <= 1'b1;
                        rmode              <= RM_ARRAY;
                    end
                    state <= SQ_IDLE;
                end
                default: begin
                    state <= SQ_IDLE;
                    rmode <= RM_ARRAY;
                end
            endcase
        end
    end

    // R1: reset leaves status 0x80 and array reads selected.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (status == 8'h80 && rmode == RM_ARRAY));

    // R4: ready stays low for the whole erase window.
    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ERASE_RUN) |-> !status[SB_READY]);

    // R9: unused status bits never become set.
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] == 1'b0 && status[3:0] == 4'h0));

    // R12: no host data lands in the array while it is read-only.
    a_r12_ro_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (array_ro && state != SQ_ERASE_RUN) |-> !mem_we);

    // R7: a bad buffered confirm flags a program error and selects array reads.
    a_r7_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_BUF_CONFIRM && wr_en && cmd != OP_CONFIRM)
        |=> (status[SB_PGM_ERR] && rmode == RM_ARRAY && state == SQ_IDLE));
endmodule

// File: rtl/flash_read_path.sv
// Read source selection. Captures mode, address and status with each read
// strobe and forms the bus word one cycle later, replicating byte-wide
// answers into every device lane. Assumes DEV_W >= 8.
module flash_read_path
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W  = 6,
    parameter int         DEV_W   = 8,
    parameter int         LANES   = 2,
    parameter logic [7:0] MFR_ID  = 8'h89,
    parameter logic [7:0] PART_ID = 8'h18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  read_mode_t             rmode,
    input  logic [7:0]             status,
    input  logic [DEV_W*LANES-1:0] mem_q,
    output logic [DEV_W*LANES-1:0] rdata,
    output logic                   rvalid
);
    localparam int OFF_W = (ADDR_W > 8) ? ADDR_W : 8;

    read_mode_t        cap_mode;
    logic [OFF_W-1:0]  cap_off;
    logic [7:0]        cap_status;
    logic [7:0]        lane_byte;

    // Query table contents for a given word offset.
    function automatic logic [7:0] query_byte(input logic [OFF_W-1:0] off);
        case (off)
            OFF_W'(8'h10): query_byte = 8'h51;
            OFF_W'(8'h11): query_byte = 8'h52;
            OFF_W'(8'h12): query_byte = 8'h59;
            OFF_W'(8'h13): query_byte = 8'h01;
            OFF_W'(8'h2C): query_byte = 8'h01;
            default:       query_byte = 8'h00;
        endcase
    endfunction

    // Capture the read context and the valid flag on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid     <= 1'b0;
            cap_mode   <= RM_ARRAY;
            cap_off    <= '0;
            cap_status <= 8'h00;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                cap_mode   <= rmode;
                cap_off    <= OFF_W'(addr);
                cap_status <= status;
            end
        end
    end

    // Byte answer shared by all lanes in the non-array modes.
    always_comb begin
        case (cap_mode)
            RM_STATUS: lane_byte = cap_status;
            RM_IDENT:  lane_byte = (cap_off == OFF_W'(0)) ? MFR_ID :
                                   (cap_off == OFF_W'(1)) ? PART_ID : 8'h00;
            RM_QUERY:  lane_byte = query_byte(cap_off);
            default:   lane_byte = 8'h00;
        endcase
    end

    // One lane slice per device: array data or the replicated byte.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_comb begin
            if (cap_mode == RM_ARRAY) begin
                rdata[ln*DEV_W +: DEV_W] = mem_q[ln*DEV_W +: DEV_W];
            end else begin
                rdata[ln*DEV_W +: DEV_W] = DEV_W'(lane_byte);
            end
        end
    end

    // R2: valid follows a strobe by exactly one cycle.
    a_r2_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
endmodule

// File: rtl/flash_cmd_top.sv
// Parallel NOR flash command interpreter top: joins the sequence decoder,
// the word array and the read path. Reads and writes share one address bus
// and are assumed not to be strobed in the same cycle.
module flash_cmd_top
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W       = 6,
    parameter int         DEV_W        = 8,
    parameter int         LANES        = 2,
    parameter int         SECTOR_WORDS = 8,
    parameter logic [7:0] MFR_ID       = 8'h89,
    parameter logic [7:0] PART_ID      = 8'h18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   array_ro,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DEV_W*LANES-1:0] wdata,
    output logic [DEV_W*LANES-1:0] rdata,
    output logic                   rvalid
);
    localparam int BUS_W = DEV_W * LANES;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [BUS_W-1:0]  mem_wdata;
    logic [BUS_W-1:0]  mem_q;
    logic [7:0]        status;
    read_mode_t        rmode;

    flash_seq_fsm #(
        .ADDR_W(ADDR_W), .DEV_W(DEV_W), .LANES(LANES), .SECTOR_WORDS(SECTOR_WORDS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .array_ro(array_ro), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .status(status), .rmode(rmode)
    );

    flash_word_array #(
        .ADDR_W(ADDR_W), .DATA_W(BUS_W)
    ) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(rd_en), .raddr(addr), .rdata(mem_q)
    );

    flash_read_path #(
        .ADDR_W(ADDR_W), .DEV_W(DEV_W), .LANES(LANES),
        .MFR_ID(MFR_ID), .PART_ID(PART_ID)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rmode(rmode),
        .status(status), .mem_q(mem_q), .rdata(rdata), .rvalid(rvalid)
    );
endmodule

// File: tb/sim_flash_cmd_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the read task queues the expected word, a monitor pops
// and compares it when rvalid appears.
module sim_flash_cmd_top;
    localparam int ADDR_W = 6;
    localparam int BUS_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n, array_ro, wr_en, rd_en;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  wdata;
    logic [BUS_W-1:0]  rdata;
    logic              rvalid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [BUS_W-1:0] exp_q[$];
    string            tag_q[$];

    always #4 clk = ~clk;

    flash_cmd_top u0 (
        .clk(clk), .rst_n(rst_n), .array_ro(array_ro), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: compare each returned word with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected rvalid", rdata, '0);
            end else begin
                logic [BUS_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata === e, t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] e,
                      input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; array_ro = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        addr = '0; wdata = '0;
        idle(3);
        check(rvalid === 1'b0, "R1 rvalid low in reset", {15'b0, rvalid}, 16'h0000);
        rst_n = 1'b1;

        // R1, R13: reset status is 0x80, replicated in both lanes
        wr(0, 16'h0070);
        rd(0, 16'h8080, "R1 R13 reset status");

        // R3: program via 0x10, status mode, then array read-back
        wr(5, 16'h0010); wr(5, 16'h1234);
        rd(5, 16'h8080, "R3 status after program");
        wr(0, 16'h00FF);
        rd(5, 16'h1234, "R2 R3 programmed word");
        wr(6, 16'h0040); wr(6, 16'hBEEF);
        wr(0, 16'h00FF);
        rd(6, 16'hBEEF, "R3 program via 0x40");

        // R1: reset returns to array mode, contents kept
        wr(0, 16'h0070);
        pulse_reset();
        rd(5, 16'h1234, "R1 array mode after reset");

        // R4: erase sector 8..15 from an unaligned address
        wr(9, 16'h0040); wr(9, 16'hA5A5);
        wr(16, 16'h0040); wr(16, 16'h5555);
        wr(11, 16'h0020); wr(11, 16'h00D0);
        rd(0, 16'h0000, "R4 ready low while erasing");
        wr(0, 16'h0050);
        idle(12);
        rd(0, 16'h8080, "R4 ready after erase, busy write ignored");
        wr(0, 16'h00FF);
        rd(8,  16'hFFFF, "R4 sector first word");
        rd(9,  16'hFFFF, "R4 sector programmed word erased");
        rd(15, 16'hFFFF, "R4 sector last word");
        rd(16, 16'h5555, "R4 next sector untouched");

        // R5: erase cancelled by 0xFF and by another code
        wr(20, 16'h0040); wr(20, 16'h1111);
        wr(20, 16'h0020); wr(20, 16'h00FF);
        rd(20, 16'h1111, "R5 erase abort 0xFF");
        wr(20, 16'h0020); wr(20, 16'h0042);
        rd(20, 16'h1111, "R5 erase abort other code");

        // R6: buffered write, count masked to low byte (0x02 -> 3 words)
        wr(35, 16'h0040); wr(35, 16'h7777);
        wr(0, 16'h0050);
        wr(32, 16'h00E8);
        rd(32, 16'h8080, "R6 ready after buffer start");
        wr(32, 16'h0102);
        wr(32, 16'hAAAA); wr(33, 16'hBBBB); wr(34, 16'hCCCC);
        wr(32, 16'h00D0);
        rd(32, 16'h8080, "R6 status after confirm");
        wr(0, 16'h00FF);
        rd(32, 16'hAAAA, "R6 buffer word 0");
        rd(33, 16'hBBBB, "R6 buffer word 1");
        rd(34, 16'hCCCC, "R6 buffer word 2");
        rd(35, 16'h7777, "R6 word past count untouched");

        // R7: bad confirm
        wr(0, 16'h0050);
        wr(40, 16'h00E8); wr(40, 16'h0000); wr(40, 16'h4242);
        wr(40, 16'h0077);
        rd(40, 16'h4242, "R7 array mode after bad confirm");
        wr(0, 16'h0070);
        rd(0, 16'h9090, "R7 program error bit");

        // R9: clear status
        wr(0, 16'h0050);
        rd(5, 16'h1234, "R9 array mode after clear");
        wr(0, 16'h0070);
        rd(0, 16'h0000, "R9 status cleared");

        // R8: lock / unlock / abort / unknown
        wr(48, 16'h0040); wr(48, 16'h3C3C);
        wr(0, 16'h0050);
        wr(48, 16'h0060); wr(48, 16'h0001);
        rd(48, 16'h8080, "R8 lock acknowledged");
        wr(0, 16'h00FF);
        rd(48, 16'h3C3C, "R8 lock leaves data");
        wr(0, 16'h0050);
        wr(48, 16'h0060); wr(48, 16'h00D0);
        rd(48, 16'h8080, "R8 unlock acknowledged");
        wr(48, 16'h0060); wr(48, 16'h00FF);
        rd(48, 16'h3C3C, "R8 lock abort to array");
        wr(48, 16'h0060); wr(48, 16'h0033);
        rd(48, 16'h3C3C, "R8 unknown lock code to array");

        // R10: identifier reads
        wr(0, 16'h0090);
        rd(0, 16'h8989, "R10 manufacturer byte");
        rd(1, 16'h1818, "R10 part byte");
        rd(2, 16'h0000, "R10 other offset");

        // R11: query reads
        wr(0, 16'h0098);
        rd(6'h10, 16'h5151, "R11 query Q");
        rd(6'h11, 16'h5252, "R11 query R");
        rd(6'h12, 16'h5959, "R11 query Y");
        rd(6'h13, 16'h0101, "R11 query 0x13");
        rd(6'h2C, 16'h0101, "R11 query 0x2C");
        rd(6'h14, 16'h0000, "R11 query other");

        // R14: unknown first-cycle code selects array mode
        wr(0, 16'h0033);
        rd(5, 16'h1234, "R14 unknown code to array");

        // R12: read-only array
        array_ro = 1'b1;
        wr(0, 16'h0050);
        wr(5, 16'h0010); wr(5, 16'h9999);
        rd(5, 16'h9090, "R12 program error when read-only");
        wr(0, 16'h00FF);
        rd(5, 16'h1234, "R12 program blocked");
        wr(0, 16'h0050);
        wr(17, 16'h0020); wr(17, 16'h00D0);
        rd(17, 16'hA0A0, "R12 erase error when read-only");
        wr(0, 16'h00FF);
        rd(16, 16'h5555, "R12 erase blocked");
        wr(0, 16'h0050);
        wr(6, 16'h00E8); wr(6, 16'h0000); wr(6, 16'hDEAD); wr(6, 16'h00D0);
        rd(6, 16'h9090, "R12 buffer error when read-only");
        wr(0, 16'h00FF);
        rd(6, 16'hBEEF, "R12 buffer blocked");
        array_ro = 1'b0;

        idle(4);
        check(exp_q.size() == 0, "R2 every read answered",
              BUS_W'(exp_q.size()), 16'h0000);
        finished = 1;
        summary();
        $finish;
    end
endmodule